// File: doc/BRIEF.md
# Exact-Match Virtual Link Multicast Forwarding Table

This block decides where a frame goes once the ingress filter has accepted it. Each lookup carries two things: the port the frame arrived on and the 16-bit virtual link identifier taken from its destination address. The block compares this pair against a small table that is loaded ahead of time. A virtual link has exactly one source but may fan out to many destinations. For that reason, a matching entry returns a bitmap of egress ports rather than a single port number.

An entry either forwards or drops. A forward entry whose bitmap is empty is treated as a drop. A key that matches no valid entry is dropped. Every result also reports whether an entry matched and which entry it was, so that a rate meter tied to that entry can be selected further down the pipeline.

Table entries are written through a simple configuration port, one entry per write. Lookups flow through a three-stage pipeline with valid/ready handshakes on both the request and the result side. While the result side keeps accepting, the pipeline takes one request per cycle.

Top module: `mcast_fwd_table`

## Requirements
- R1: After a synchronous reset, `res_valid` is 0 and every table entry is invalid, so any lookup misses until entries are written.
- R2: A lookup hits an entry only when both the ingress port and the virtual link ID equal the entry's stored values; a difference in either field alone gives a miss.
- R3: A hit on a valid forward entry with a non-zero bitmap gives `res_hit`=1, `res_fwd`=1, `res_bitmap` equal to the entry's bitmap, and `res_idx` equal to the entry index.
- R4: A lookup that hits no valid entry gives `res_hit`=0, `res_fwd`=0, `res_bitmap`=0 and `res_idx`=0.
- R5: A hit on an entry written with `cfg_fwd`=0 (drop action) gives `res_hit`=1, the entry's index, `res_fwd`=0 and `res_bitmap`=0.
- R6: A hit on an entry written with `cfg_fwd`=1 and an all-zero bitmap is reported as a drop: `res_fwd`=0, `res_bitmap`=0, with `res_hit`=1 and the entry's index.
- R7: When several valid entries hold the same key, the entry with the lowest index is reported.
- R8: A request accepted at a clock edge shows its result with `res_valid`=1 after the third edge that follows, counting the accepting edge as the first. While `res_ready` stays 1, a new request is accepted and a result delivered on every cycle.
- R9: While `res_valid`=1 and `res_ready`=0, the result fields stay unchanged. Once the pipeline is full, `req_ready` drops to 0. No result is lost or reordered.
- R10: A configuration write replaces the addressed entry from the next lookup on. Writing with `cfg_en`=0 invalidates that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write one table entry |
| cfg_idx | input | IDX_W | Entry index being written |
| cfg_en | input | 1 | 1 makes the entry valid, 0 invalidates it |
| cfg_port | input | PORT_W | Ingress port part of the key |
| cfg_vlid | input | VL_W | Virtual link part of the key |
| cfg_fwd | input | 1 | Action: 1 forward, 0 drop |
| cfg_bitmap | input | NUM_PORTS | Egress port bitmap for forward |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Lookup request accepted this cycle |
| req_port | input | PORT_W | Ingress port of the frame |
| req_vlid | input | VL_W | Virtual link ID of the frame |
| res_valid | output | 1 | Result present |
| res_ready | input | 1 | Downstream takes the result |
| res_fwd | output | 1 | 1 forward, 0 drop |
| res_bitmap | output | NUM_PORTS | Egress ports, zero on drop |
| res_hit | output | 1 | An entry matched |
| res_idx | output | IDX_W | Matching entry index, zero on miss |

## Verification
A stale or corrupted key register shows up at the ports as a wrong hit or a wrong miss on the very next lookup of that key, three edges after acceptance. A corrupted action word shows up as a wrong bitmap or a wrong forward flag in that same cycle. Mishandling of the pipeline valid bits appears within one or two cycles under backpressure: a result is dropped, duplicated or reordered, or a field changes while `res_ready` is held low. For that reason the bench stalls the output with three requests in flight and checks the order in which they drain. A priority encoder that favours the wrong entry shows only when keys are duplicated, so duplicates are loaded and then the winning entry is removed.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

  typedef enum logic {
    ACT_DROP = 1'b0,
    ACT_FWD  = 1'b1
  } fwd_act_e;

  // Bitmap stored in the action memory: drop entries hold zero, so a
  // forward entry with an empty bitmap also reads back as a drop.
  function automatic logic [63:0] eff_bitmap(input fwd_act_e act,
                                             input logic [63:0] bm);
    return (act == ACT_FWD) ? bm : 64'd0;
  endfunction

endpackage

// File: rtl/fwd_entry_store.sv
module fwd_entry_store #(
  parameter int NUM_ENTRIES = 16,
  parameter int PORT_W      = 3,
  parameter int VL_W        = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_valid,
  input  logic [PORT_W-1:0] wr_port,
  input  logic [VL_W-1:0]   wr_vlid,
  output logic              ent_valid [NUM_ENTRIES],
  output logic [PORT_W-1:0] ent_port  [NUM_ENTRIES],
  output logic [VL_W-1:0]   ent_vlid  [NUM_ENTRIES]
);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    logic sel;
    assign sel = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk) begin
      if (rst) begin
        ent_valid[g] <= 1'b0;
      end else if (sel) begin
        ent_valid[g] <= wr_valid;
      end
    end

    always_ff @(posedge clk) begin
      if (sel) begin
        ent_port[g] <= wr_port;
        ent_vlid[g] <= wr_vlid;
      end
    end
  end

endmodule

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int NUM_ENTRIES = 16,
  parameter int PORT_W      = 3,
  parameter int VL_W        = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic              ent_valid [NUM_ENTRIES],
  input  logic [PORT_W-1:0] ent_port  [NUM_ENTRIES],
  input  logic [VL_W-1:0]   ent_vlid  [NUM_ENTRIES],
  input  logic [PORT_W-1:0] key_port,
  input  logic [VL_W-1:0]   key_vlid,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);

  logic [NUM_ENTRIES-1:0] eq;

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
    assign eq[g] = ent_valid[g] && (ent_port[g] == key_port) &&
                   (ent_vlid[g] == key_vlid);
  end

  // Lowest matching index wins.
  always_comb begin
    hit = 1'b0;
    idx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (eq[i]) begin
        hit = 1'b1;
        idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/fwd_action_ram.sv
module fwd_action_ram #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int ADDR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) begin
      mem[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata <= mem[raddr];
    end
  end

endmodule

// File: rtl/mcast_fwd_table.sv
module mcast_fwd_table
  import fwd_pkg::*;
#(
  parameter int NUM_PORTS   = 8,
  parameter int NUM_ENTRIES = 16,
  parameter int VL_W        = 16,
  localparam int PORT_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cfg_we,
  input  logic [IDX_W-1:0]     cfg_idx,
  input  logic                 cfg_en,
  input  logic [PORT_W-1:0]    cfg_port,
  input  logic [VL_W-1:0]      cfg_vlid,
  input  logic                 cfg_fwd,
  input  logic [NUM_PORTS-1:0] cfg_bitmap,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [PORT_W-1:0]    req_port,
  input  logic [VL_W-1:0]      req_vlid,
  output logic                 res_valid,
  input  logic                 res_ready,
  output logic                 res_fwd,
  output logic [NUM_PORTS-1:0] res_bitmap,
  output logic                 res_hit,
  output logic [IDX_W-1:0]     res_idx
);

  // Table key storage
  logic              ent_valid [NUM_ENTRIES];
  logic [PORT_W-1:0] ent_port  [NUM_ENTRIES];
  logic [VL_W-1:0]   ent_vlid  [NUM_ENTRIES];

  fwd_entry_store #(
    .NUM_ENTRIES(NUM_ENTRIES), .PORT_W(PORT_W), .VL_W(VL_W)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (cfg_we),
    .wr_idx   (cfg_idx),
    .wr_valid (cfg_en),
    .wr_port  (cfg_port),
    .wr_vlid  (cfg_vlid),
    .ent_valid(ent_valid),
    .ent_port (ent_port),
    .ent_vlid (ent_vlid)
  );

  // Pipeline control
  logic              a_valid, b_valid, o_valid;
  logic              a_ld, b_ld, o_ld;
  logic [PORT_W-1:0] a_port;
  logic [VL_W-1:0]   a_vlid;
  logic              b_hit, o_hit;
  logic [IDX_W-1:0]  b_idx, o_idx;
  logic              m_hit;
  logic [IDX_W-1:0]  m_idx;

  assign o_ld      = !o_valid || res_ready;
  assign b_ld      = !b_valid || o_ld;
  assign a_ld      = !a_valid || b_ld;
  assign req_ready = a_ld;

  // Stage A: capture key
  always_ff @(posedge clk) begin
    if (rst) begin
      a_valid <= 1'b0;
    end else if (a_ld) begin
      a_valid <= req_valid;
    end
  end

  always_ff @(posedge clk) begin
    if (a_ld && req_valid) begin
      a_port <= req_port;
      a_vlid <= req_vlid;
    end
  end

  fwd_match #(
    .NUM_ENTRIES(NUM_ENTRIES), .PORT_W(PORT_W), .VL_W(VL_W)
  ) u_match (
    .ent_valid(ent_valid),
    .ent_port (ent_port),
    .ent_vlid (ent_vlid),
    .key_port (a_port),
    .key_vlid (a_vlid),
    .hit      (m_hit),
    .idx      (m_idx)
  );

  // Stage B: register match outcome
  always_ff @(posedge clk) begin
    if (rst) begin
      b_valid <= 1'b0;
      b_hit   <= 1'b0;
      b_idx   <= '0;
    end else if (b_ld) begin
      b_valid <= a_valid;
      b_hit   <= a_valid && m_hit;
      b_idx   <= m_idx;
    end
  end

  // Action memory: read with the match index as the output stage loads
  logic [NUM_PORTS-1:0] wr_bm;
  logic [NUM_PORTS-1:0] rd_bm;
  logic [63:0]          wr_bm_wide;

  assign wr_bm_wide = eff_bitmap(fwd_act_e'(cfg_fwd), 64'(cfg_bitmap));
  assign wr_bm      = wr_bm_wide[NUM_PORTS-1:0];

  fwd_action_ram #(
    .DEPTH(NUM_ENTRIES), .DATA_W(NUM_PORTS)
  ) u_act (
    .clk  (clk),
    .we   (cfg_we),
    .waddr(cfg_idx),
    .wdata(wr_bm),
    .re   (o_ld),
    .raddr(b_idx),
    .rdata(rd_bm)
  );

  // Output stage
  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_hit   <= 1'b0;
      o_idx   <= '0;
    end else if (o_ld) begin
      o_valid <= b_valid;
      o_hit   <= b_hit;
      o_idx   <= b_hit ? b_idx : '0;
    end
  end

  assign res_valid  = o_valid;
  assign res_hit    = o_hit;
  assign res_idx    = o_idx;
  assign res_bitmap = o_hit ? rd_bm : '0;
  assign res_fwd    = |res_bitmap;

endmodule

// File: rtl/fwd_table_checker.sv
module fwd_table_checker #(
  parameter int NUM_PORTS   = 8,
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W      = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 req_ready,
  input logic                 res_valid,
  input logic                 res_ready,
  input logic                 res_fwd,
  input logic [NUM_PORTS-1:0] res_bitmap,
  input logic                 res_hit,
  input logic [IDX_W-1:0]     res_idx
);

  p_reset_clear_r1: assert property (@(posedge clk) rst |=> !res_valid)
    else $error("R1: result valid after reset");

  p_idx_range_r3: assert property (@(posedge clk) disable iff (rst)
    (res_valid && res_hit) |-> (int'(res_idx) < NUM_ENTRIES))
    else $error("R3: index out of range");

  p_miss_drop_r4: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_hit) |-> (!res_fwd && res_idx == '0 && res_bitmap == '0))
    else $error("R4: miss not reported as drop");

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=>
      (res_valid && $stable(res_bitmap) && $stable(res_idx) && $stable(res_hit)))
    else $error("R9: result changed under backpressure");

  p_stall_full_r9: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready && !req_ready) |=> (!req_ready || res_ready || !res_valid))
    else $error("R9: request accepted while stalled");

endmodule

bind mcast_fwd_table fwd_table_checker #(
  .NUM_PORTS(NUM_PORTS), .NUM_ENTRIES(NUM_ENTRIES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_fwd   (res_fwd),
  .res_bitmap(res_bitmap),
  .res_hit   (res_hit),
  .res_idx   (res_idx)
);

// File: tb/mcast_fwd_table_tb_top.sv
module mcast_fwd_table_tb_top;

  localparam int NP = 8;
  localparam int NE = 16;
  localparam int VW = 16;
  localparam int PW = 3;
  localparam int IW = 4;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cfg_we = 1'b0;
  logic [IW-1:0] cfg_idx = '0;
  logic          cfg_en = 1'b0;
  logic [PW-1:0] cfg_port = '0;
  logic [VW-1:0] cfg_vlid = '0;
  logic          cfg_fwd = 1'b0;
  logic [NP-1:0] cfg_bitmap = '0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [PW-1:0] req_port = '0;
  logic [VW-1:0] req_vlid = '0;
  logic          res_valid;
  logic          res_ready = 1'b1;
  logic          res_fwd;
  logic [NP-1:0] res_bitmap;
  logic          res_hit;
  logic [IW-1:0] res_idx;

  int checks = 0;
  int fails  = 0;

  always #2 clk = ~clk;

  mcast_fwd_table #(.NUM_PORTS(NP), .NUM_ENTRIES(NE), .VL_W(VW)) dut_i (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en), .cfg_port(cfg_port),
    .cfg_vlid(cfg_vlid), .cfg_fwd(cfg_fwd), .cfg_bitmap(cfg_bitmap),
    .req_valid(req_valid), .req_ready(req_ready), .req_port(req_port),
    .req_vlid(req_vlid), .res_valid(res_valid), .res_ready(res_ready),
    .res_fwd(res_fwd), .res_bitmap(res_bitmap), .res_hit(res_hit),
    .res_idx(res_idx)
  );

  // port(3) vlid(16) hit(1) fwd(1) bitmap(8) idx(4)
  localparam int VN = 10;
  localparam logic [32:0] VEC [VN] = '{
    {3'd1, 16'h0100, 1'b1, 1'b1, 8'h0F, 4'd0},
    {3'd2, 16'h0100, 1'b1, 1'b1, 8'hF0, 4'd1},
    {3'd3, 16'h0100, 1'b0, 1'b0, 8'h00, 4'd0},
    {3'd1, 16'h0101, 1'b1, 1'b0, 8'h00, 4'd2},
    {3'd1, 16'h0102, 1'b0, 1'b0, 8'h00, 4'd0},
    {3'd3, 16'h0200, 1'b1, 1'b0, 8'h00, 4'd3},
    {3'd5, 16'hBEEF, 1'b1, 1'b1, 8'h81, 4'd4},
    {3'd7, 16'hFFFF, 1'b1, 1'b1, 8'h80, 4'd15},
    {3'd0, 16'h0000, 1'b0, 1'b0, 8'h00, 4'd0},
    {3'd4, 16'hBEEF, 1'b0, 1'b0, 8'h00, 4'd0}
  };

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R3 forward hit";
      1: return "R2 same link other port";
      2: return "R2 port mismatch miss R4";
      3: return "R5 drop action";
      4: return "R2 link mismatch miss R4";
      5: return "R6 empty bitmap drop";
      6: return "R7 duplicate lowest index";
      7: return "R3 last entry";
      8: return "R4 invalid zero entries";
      default: return "R2 port mismatch on dup key";
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input int idx, input bit en, input int port,
                           input int vl, input bit fwd, input int bm);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = IW'(idx); cfg_en = en; cfg_port = PW'(port);
    cfg_vlid = VW'(vl); cfg_fwd = fwd; cfg_bitmap = NP'(bm);
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic check_res(input bit ehit, input bit efwd, input int ebm,
                           input int eidx, input string tag);
    chk(res_valid == 1'b1, {tag, " valid"}, 32'(res_valid), 32'd1);
    chk(res_hit == ehit, {tag, " hit"}, 32'(res_hit), 32'(ehit));
    chk(res_fwd == efwd, {tag, " fwd"}, 32'(res_fwd), 32'(efwd));
    chk(res_bitmap == NP'(ebm), {tag, " bitmap"}, 32'(res_bitmap), 32'(ebm));
    chk(res_idx == IW'(eidx), {tag, " idx"}, 32'(res_idx), 32'(eidx));
  endtask

  // Single lookup with result_ready high; checks R8 latency.
  task automatic lookup(input int port, input int vl, input bit ehit,
                        input bit efwd, input int ebm, input int eidx,
                        input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_port = PW'(port); req_vlid = VW'(vl);
    chk(req_ready == 1'b1, "R8 ready when idle", 32'(req_ready), 32'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(res_valid == 1'b0, "R8 not early (edge 1)", 32'(res_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 not early (edge 2)", 32'(res_valid), 32'd0);
    @(posedge clk);
    @(negedge clk);
    check_res(ehit, efwd, ebm, eidx, tag);
  endtask

  task automatic send(input int port, input int vl);
    @(negedge clk);
    req_valid = 1'b1; req_port = PW'(port); req_vlid = VW'(vl);
    while (!req_ready) begin
      @(negedge clk);
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid in reset", 32'(res_valid), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk(res_valid == 1'b0, "R1 res_valid after reset", 32'(res_valid), 32'd0);
    // R1: empty table misses
    lookup(0, 0, 1'b0, 1'b0, 0, 0, "R1 empty table miss");
    lookup(1, 16'h0100, 1'b0, 1'b0, 0, 0, "R1 empty table miss key");

    cfg_write(0, 1, 1, 16'h0100, 1, 8'h0F);
    cfg_write(1, 1, 2, 16'h0100, 1, 8'hF0);
    cfg_write(2, 1, 1, 16'h0101, 0, 8'hFF);
    cfg_write(3, 1, 3, 16'h0200, 1, 8'h00);
    cfg_write(4, 1, 5, 16'hBEEF, 1, 8'h81);
    cfg_write(5, 1, 5, 16'hBEEF, 1, 8'h7E);
    cfg_write(15, 1, 7, 16'hFFFF, 1, 8'h80);

    for (int i = 0; i < VN; i++) begin
      lookup(int'(VEC[i][32:30]), int'(VEC[i][29:14]), VEC[i][13], VEC[i][12],
             int'(VEC[i][11:4]), int'(VEC[i][3:0]), vec_tag(i));
    end

    // R10: overwrite, invalidate; R7: next duplicate takes over
    cfg_write(0, 1, 1, 16'h0100, 1, 8'h33);
    lookup(1, 16'h0100, 1'b1, 1'b1, 8'h33, 0, "R10 overwrite");
    cfg_write(0, 0, 1, 16'h0100, 1, 8'h33);
    lookup(1, 16'h0100, 1'b0, 1'b0, 0, 0, "R10 invalidate");
    cfg_write(4, 0, 5, 16'hBEEF, 1, 8'h81);
    lookup(5, 16'hBEEF, 1'b1, 1'b1, 8'h7E, 5, "R7 R10 next duplicate");

    // R8: back-to-back throughput
    @(negedge clk);
    req_valid = 1'b1; req_port = 3'd2; req_vlid = 16'h0100;
    @(negedge clk);
    req_port = 3'd7; req_vlid = 16'hFFFF;
    @(negedge clk);
    req_port = 3'd1; req_vlid = 16'h0101;
    @(negedge clk);
    req_valid = 1'b0;
    check_res(1'b1, 1'b1, 8'hF0, 1, "R8 stream first");
    @(negedge clk);
    check_res(1'b1, 1'b1, 8'h80, 15, "R8 stream second");
    @(negedge clk);
    check_res(1'b1, 1'b0, 8'h00, 2, "R8 stream third");
    @(negedge clk);
    chk(res_valid == 1'b0, "R8 stream drained", 32'(res_valid), 32'd0);

    // R9: backpressure with three in flight
    res_ready = 1'b0;
    send(2, 16'h0100);
    send(3, 16'h0200);
    send(7, 16'hFFFF);
    @(negedge clk);
    chk(req_ready == 1'b0, "R9 req_ready low when full", 32'(req_ready), 32'd0);
    check_res(1'b1, 1'b1, 8'hF0, 1, "R9 held first");
    repeat (3) @(negedge clk);
    check_res(1'b1, 1'b1, 8'hF0, 1, "R9 still held first");
    res_ready = 1'b1;
    @(negedge clk);
    check_res(1'b1, 1'b0, 8'h00, 3, "R9 drain second");
    @(negedge clk);
    check_res(1'b1, 1'b1, 8'h80, 15, "R9 drain third");
    @(negedge clk);
    chk(res_valid == 1'b0, "R9 drained", 32'(res_valid), 32'd0);

    // R1: reset mid-operation clears table
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(res_valid == 1'b0, "R1 res_valid after second reset", 32'(res_valid), 32'd0);
    lookup(7, 16'hFFFF, 1'b0, 1'b0, 0, 0, "R1 table cleared by reset");

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule